// File: doc/BRIEF.md
# Telegram-Gated Signal-Strength Peak Detector

This block sits behind the signal-strength ADC of a receiver. Each ADC strobe carries one unsigned 8-bit level. The levels are summed four at a time in an integrate-and-dump filter. The sum, divided by four, is passed on as an averaged level at one quarter of the strobe rate. Two peak trackers read that averaged stream.

The window tracker measures the strength of one accepted telegram. A frame-sync pulse clears it. After that pulse it waits a programmable number of data-bit ticks, and then it records the largest averaged level until an end-of-message pulse arrives. At the end of message its value is copied into the held result `win_peak`. That output therefore always shows the peak of the last telegram that was received in full.

The running tracker follows the averaged level whenever the receiver-active input is high. A read strobe reloads it with the current averaged level, so each read starts a fresh measurement.

Top module: `rssi_peak_unit`

## Requirements
- R1: After reset, `avg_data`, `avg_vld`, `win_peak` and `run_peak` are all zero.
- R2: The block sums four consecutive `smp_vld` samples in a 10-bit accumulator. In the cycle after the fourth strobe, `avg_vld` is high for one cycle and `avg_data` holds the sum shifted right by two (truncated). `avg_data` keeps that value until the next group completes.
- R3: While the telegram window is open, the window tracker takes each averaged level that is strictly greater than the level it holds. It therefore keeps the maximum.
- R4: A `fsync` pulse sets the window tracker to zero, so one telegram's peak never carries into the next.
- R5: If `eom` arrives after a `fsync` and before any other `eom`, the window tracker's value is copied to `win_peak` in the next cycle.
- R6: With `delay_bits` = N > 0, the window opens on the Nth `bit_tick` pulse after `fsync`. Averaged levels completed before that are not counted. With N = 0 the window opens in the cycle right after `fsync`.
- R7: `win_peak` changes only at a qualifying `eom`. An `eom` without a pending `fsync` leaves it unchanged. Averaged levels outside a window also leave it unchanged.
- R8: The running tracker takes larger averaged levels only while `rx_run` is high. While `rx_run` is low it holds its value.
- R9: A `rd_strobe` pulse loads `run_peak` with the current `avg_data` in the next cycle. The load takes priority over tracking, and tracking then continues from the loaded value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| smp_vld | input | 1 | ADC sample strobe |
| smp_data | input | 8 | Unsigned signal-strength sample |
| bit_tick | input | 1 | One pulse per received data bit |
| fsync | input | 1 | Frame-sync detected pulse |
| eom | input | 1 | End-of-message pulse |
| delay_bits | input | 4 | Data bits to skip after frame sync before observing |
| rx_run | input | 1 | Receiver active, enables the running tracker |
| rd_strobe | input | 1 | Read access to the running tracker's register |
| avg_vld | output | 1 | One-cycle pulse marking a new averaged level |
| avg_data | output | 8 | Latest averaged level |
| win_peak | output | 8 | Peak of the last complete telegram |
| run_peak | output | 8 | Running tracker's peak since the last read |

## Verification
The averager is tried with a mixed group whose sum has a remainder, with all-full-scale samples, and with a nearly-zero group. These tell correct truncation and accumulator width apart from overflow or rounding. The window tracker receives telegrams whose peaks rise and then fall. It then gets a second telegram with lower levels, which shows whether the clear at frame sync works. A delayed telegram puts large levels before and between its bit ticks, to separate a correct start delay from an early opening. The running tracker receives groups with `rx_run` high and with it low, and reads are issued both above and below the tracked level. These patterns distinguish gating by `rx_run` from reload on read.

// File: rtl/rssi_pk_pkg.sv
// Package: shared types for the signal-strength peak detector.
// Assumes: nothing beyond IEEE 1800-2017.
package rssi_pk_pkg;
    // Telegram window state: idle, waiting for the bit delay, observing.
    typedef enum logic [1:0] {
        GATE_IDLE = 2'd0,
        GATE_WAIT = 2'd1,
        GATE_OPEN = 2'd2
    } gate_state_e;
endpackage

// File: rtl/rssi_avg.sv
// Module: rssi_avg
// Integrate-and-dump averager. It sums GRP consecutive strobed samples and
// emits the sum divided by GRP as a one-cycle valid pulse with held data.
// Assumes: GRP is a power of two >= 2; the accumulator width is derived so
// that it never overflows (8-bit samples, GRP=4 -> 10 bits).
module rssi_avg #(
    parameter int SMP_W = 8,
    parameter int GRP   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp_vld,
    input  logic [SMP_W-1:0] smp_data,
    output logic             avg_vld,
    output logic [SMP_W-1:0] avg_data
);
    localparam int CNT_W = $clog2(GRP);
    localparam int ACC_W = SMP_W + CNT_W;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(GRP - 1);

    logic [CNT_W-1:0] cnt_q;
    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] sum;

    // Running sum including the sample presented this cycle.
    always_comb begin
        sum = acc_q + ACC_W'(smp_data);
    end

    // Integrate on each strobe; dump and publish on the last of the group.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            acc_q    <= '0;
            avg_vld  <= 1'b0;
            avg_data <= '0;
        end else begin
            avg_vld <= 1'b0;
            if (smp_vld) begin
                if (cnt_q == LAST) begin
                    cnt_q    <= '0;
                    acc_q    <= '0;
                    avg_vld  <= 1'b1;
                    avg_data <= sum[ACC_W-1:CNT_W];
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                    acc_q <= sum;
                end
            end
        end
    end
endmodule

// File: rtl/rssi_win_gate.sv
// Module: rssi_win_gate
// Telegram observation window. Frame sync starts a new telegram and waits
// for a set number of data-bit ticks before opening. End of message closes
// the window. Frame sync takes priority over end of message.
// Assumes: fsync, eom and bit_tick are single-cycle pulses.
module rssi_win_gate
    import rssi_pk_pkg::*;
#(
    parameter int DLY_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fsync,
    input  logic             eom,
    input  logic             bit_tick,
    input  logic [DLY_W-1:0] delay_bits,
    output logic             win_open,
    output logic             win_armed
);
    gate_state_e      state_q;
    logic [DLY_W-1:0] bits_q;
    logic [DLY_W:0]   bits_nx;

    // Count of bit ticks after this one.
    always_comb begin
        bits_nx = {1'b0, bits_q} + 1'b1;
    end

    // Window state sequencing and bit-delay counting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= GATE_IDLE;
            bits_q  <= '0;
        end else if (fsync) begin
            bits_q  <= '0;
            state_q <= (delay_bits == '0) ? GATE_OPEN : GATE_WAIT;
        end else if (eom) begin
            state_q <= GATE_IDLE;
        end else if (state_q == GATE_WAIT && bit_tick) begin
            if (bits_nx == {1'b0, delay_bits}) begin
                state_q <= GATE_OPEN;
            end else begin
                bits_q <= bits_nx[DLY_W-1:0];
            end
        end
    end

    // Decoded window flags.
    always_comb begin
        win_open  = (state_q == GATE_OPEN);
        win_armed = (state_q != GATE_IDLE);
    end
endmodule

// File: rtl/rssi_peak_track.sv
// Module: rssi_peak_track
// Single peak register. Priority: clear, then load, then update when
// enabled and a valid level is strictly above the stored one.
// Assumes: unsigned levels.
module rssi_peak_track #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         en,
    input  logic         lvl_vld,
    input  logic [W-1:0] lvl,
    output logic [W-1:0] peak
);
    // Maximum tracking with clear and reload.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            peak <= '0;
        end else if (clr) begin
            peak <= '0;
        end else if (load) begin
            peak <= load_val;
        end else if (en && lvl_vld && (lvl > peak)) begin
            peak <= lvl;
        end
    end
endmodule

// File: rtl/rssi_peak_unit.sv
// Module: rssi_peak_unit (top)
// Averages ADC signal-strength samples in groups of four and feeds two peak
// trackers: a telegram-window tracker whose result is latched at end of
// message, and a running tracker gated by receiver activity and reloaded
// on read.
// Assumes: all control inputs are synchronous single-cycle pulses except
// rx_run and delay_bits, which are levels.
module rssi_peak_unit #(
    parameter int SMP_W = 8,
    parameter int GRP   = 4,
    parameter int DLY_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp_vld,
    input  logic [SMP_W-1:0] smp_data,
    input  logic             bit_tick,
    input  logic             fsync,
    input  logic             eom,
    input  logic [DLY_W-1:0] delay_bits,
    input  logic             rx_run,
    input  logic             rd_strobe,
    output logic             avg_vld,
    output logic [SMP_W-1:0] avg_data,
    output logic [SMP_W-1:0] win_peak,
    output logic [SMP_W-1:0] run_peak
);
    logic             win_open;
    logic             win_armed;
    logic [SMP_W-1:0] tel_peak;

    rssi_avg #(.SMP_W(SMP_W), .GRP(GRP)) u_avg (
        .clk      (clk),
        .rst_n    (rst_n),
        .smp_vld  (smp_vld),
        .smp_data (smp_data),
        .avg_vld  (avg_vld),
        .avg_data (avg_data)
    );

    rssi_win_gate #(.DLY_W(DLY_W)) u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .fsync      (fsync),
        .eom        (eom),
        .bit_tick   (bit_tick),
        .delay_bits (delay_bits),
        .win_open   (win_open),
        .win_armed  (win_armed)
    );

    rssi_peak_track #(.W(SMP_W)) u_tel_trk (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (fsync),
        .load     (1'b0),
        .load_val ('0),
        .en       (win_open),
        .lvl_vld  (avg_vld),
        .lvl      (avg_data),
        .peak     (tel_peak)
    );

    rssi_peak_track #(.W(SMP_W)) u_run_trk (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (1'b0),
        .load     (rd_strobe),
        .load_val (avg_data),
        .en       (rx_run),
        .lvl_vld  (avg_vld),
        .lvl      (avg_data),
        .peak     (run_peak)
    );

    // Result register: captures the telegram peak at a qualifying end of message.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_peak <= '0;
        end else if (eom && win_armed) begin
            win_peak <= tel_peak;
        end
    end
endmodule

// File: rtl/rssi_peak_unit_chk.sv
// Module: rssi_peak_unit_chk
// Property checker for rssi_peak_unit, attached with bind below.
// Assumes: observation only; drives nothing.
module rssi_peak_unit_chk #(
    parameter int SMP_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             smp_vld,
    input logic             eom,
    input logic             rx_run,
    input logic             rd_strobe,
    input logic             avg_vld,
    input logic [SMP_W-1:0] avg_data,
    input logic [SMP_W-1:0] win_peak,
    input logic [SMP_W-1:0] run_peak
);
    // R2: a new average only follows a sample strobe.
    p_avg_after_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        avg_vld |-> $past(smp_vld));

    // R2: averaged data holds between valid pulses.
    p_avg_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !avg_vld |=> $stable(avg_data) || avg_vld);

    // R7: the telegram result changes only after an end of message.
    p_win_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !eom |=> $stable(win_peak));

    // R8: running tracker holds while the receiver is idle and no read occurs.
    p_run_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_run && !rd_strobe) |=> $stable(run_peak));

    // R8: without a read the running peak never decreases.
    p_run_mono_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_strobe |=> run_peak >= $past(run_peak));

    // R9: a read reloads the running peak with the current average.
    p_run_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_strobe |=> run_peak == $past(avg_data));
endmodule

bind rssi_peak_unit rssi_peak_unit_chk #(.SMP_W(SMP_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_vld   (smp_vld),
    .eom       (eom),
    .rx_run    (rx_run),
    .rd_strobe (rd_strobe),
    .avg_vld   (avg_vld),
    .avg_data  (avg_data),
    .win_peak  (win_peak),
    .run_peak  (run_peak)
);

// File: tb/rssi_peak_unit_tb.sv
// Directed bench for rssi_peak_unit: one task per scenario.
module rssi_peak_unit_tb;
    localparam time CLK_PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       smp_vld = 1'b0;
    logic [7:0] smp_data = '0;
    logic       bit_tick = 1'b0;
    logic       fsync = 1'b0;
    logic       eom = 1'b0;
    logic [3:0] delay_bits = '0;
    logic       rx_run = 1'b0;
    logic       rd_strobe = 1'b0;
    logic       avg_vld;
    logic [7:0] avg_data;
    logic [7:0] win_peak;
    logic [7:0] run_peak;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rssi_peak_unit u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .smp_vld    (smp_vld),
        .smp_data   (smp_data),
        .bit_tick   (bit_tick),
        .fsync      (fsync),
        .eom        (eom),
        .delay_bits (delay_bits),
        .rx_run     (rx_run),
        .rd_strobe  (rd_strobe),
        .avg_vld    (avg_vld),
        .avg_data   (avg_data),
        .win_peak   (win_peak),
        .run_peak   (run_peak)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Sends four samples on consecutive cycles, then lets the result settle.
    task automatic send_grp(input int a, input int b, input int c, input int d);
        int v[4];
        v = '{a, b, c, d};
        foreach (v[i]) begin
            smp_vld = 1'b1;
            smp_data = 8'(v[i]);
            @(negedge clk);
        end
        smp_vld = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic pulse_fsync();
        fsync = 1'b1; @(negedge clk); fsync = 1'b0; @(negedge clk);
    endtask
    task automatic pulse_eom();
        eom = 1'b1; @(negedge clk); eom = 1'b0; @(negedge clk);
    endtask
    task automatic pulse_tick();
        bit_tick = 1'b1; @(negedge clk); bit_tick = 1'b0; @(negedge clk);
    endtask
    task automatic pulse_rd();
        rd_strobe = 1'b1; @(negedge clk); rd_strobe = 1'b0; @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1", "avg_data", avg_data, 0);
        chk("R1", "avg_vld", avg_vld, 0);
        chk("R1", "win_peak", win_peak, 0);
        chk("R1", "run_peak", run_peak, 0);
    endtask

    task automatic t_average();
        // 10+20+30+41 = 101 -> 25; check the one-cycle valid pulse.
        int v[4];
        v = '{10, 20, 30, 41};
        foreach (v[i]) begin
            smp_vld = 1'b1;
            smp_data = 8'(v[i]);
            @(negedge clk);
        end
        smp_vld = 1'b0;
        chk("R2", "avg_vld pulse", avg_vld, 1);
        chk("R2", "avg_data mixed", avg_data, 25);
        @(negedge clk);
        chk("R2", "avg_vld drop", avg_vld, 0);
        chk("R2", "avg_data held", avg_data, 25);
        send_grp(255, 255, 255, 255);
        chk("R2", "avg_data full scale", avg_data, 255);
        send_grp(0, 0, 0, 3);
        chk("R2", "avg_data truncation", avg_data, 0);
        chk("R7", "win_peak outside window", win_peak, 0);
    endtask

    task automatic t_telegram();
        delay_bits = 4'd0;
        pulse_fsync();
        send_grp(50, 50, 50, 50);
        send_grp(80, 80, 80, 80);
        send_grp(60, 60, 60, 60);
        chk("R7", "win_peak before eom", win_peak, 0);
        pulse_eom();
        chk("R3", "win_peak max of telegram", win_peak, 80);
        chk("R5", "win_peak latched at eom", win_peak, 80);
        chk("R8", "run_peak idle receiver", run_peak, 0);
    endtask

    task automatic t_clear();
        pulse_fsync();
        send_grp(30, 30, 30, 30);
        send_grp(40, 40, 40, 40);
        pulse_eom();
        chk("R4", "win_peak after clear", win_peak, 40);
    endtask

    task automatic t_delay();
        delay_bits = 4'd2;
        pulse_fsync();
        send_grp(200, 200, 200, 200);
        pulse_tick();
        send_grp(150, 150, 150, 150);
        pulse_tick();
        send_grp(70, 70, 70, 70);
        send_grp(90, 90, 90, 90);
        pulse_eom();
        chk("R6", "win_peak with bit delay", win_peak, 90);
        delay_bits = 4'd0;
    endtask

    task automatic t_hold();
        send_grp(250, 250, 250, 250);
        chk("R7", "win_peak ignores out-of-window", win_peak, 90);
        pulse_eom();
        chk("R7", "win_peak ignores stray eom", win_peak, 90);
    endtask

    task automatic t_running();
        send_grp(20, 20, 20, 20);
        pulse_rd();
        chk("R9", "run_peak load on read", run_peak, 20);
        rx_run = 1'b1;
        send_grp(100, 100, 100, 100);
        send_grp(150, 150, 150, 150);
        send_grp(120, 120, 120, 120);
        chk("R8", "run_peak tracks max", run_peak, 150);
        rx_run = 1'b0;
        send_grp(220, 220, 220, 220);
        chk("R8", "run_peak held when idle", run_peak, 150);
        rx_run = 1'b1;
        send_grp(40, 40, 40, 40);
        pulse_rd();
        chk("R9", "run_peak reload below peak", run_peak, 40);
        send_grp(70, 70, 70, 70);
        chk("R9", "run_peak restarts from load", run_peak, 70);
        rx_run = 1'b0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog R1..: actual timeout expected completion");
        finish_run();
    end

    // Scenario sequence.
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_average();
        t_telegram();
        t_clear();
        t_delay();
        t_hold();
        t_running();
        finish_run();
    end
endmodule